// File: doc/BRIEF.md
# SIMD Lane-Group Co-Issue Packer

This block sits beside a warp scheduler and works in the same cycle as it. When the scheduler has just sent a primary instruction to an arithmetic-type functional unit, the primary usually fills only some of the unit's lane groups ("sets"). The packer walks the other warps in scheduler priority order and grants those whose next instruction can share the issue slot. A warp can share the slot if it is ready, has no hazard, targets the same unit class, and its active sets land only in sets that are still free.

The grant vector comes out combinationally in the issue cycle. A granted warp is co-issued and advances its instruction buffer by one entry. The merged occupancy of the composite instruction is registered at the clock edge. Each occupied set in it is tagged with the warp that owns it, so that writeback can release registers for every participating warp.

Top module: `simd_coissue_packer`

## Requirements
- R1: Packing happens only when `part_en` and `prim_valid` are both high and `prim_class` is neither 0 (none) nor 7 (memory). In any other case `grant` is all zero and the merged result holds only the primary's sets.
- R2: The free-set count is the number of zero bits in `prim_occ`. When it is zero (`prim_occ` all ones), no warp is granted.
- R3: Slot k of `prio_list` (bits k*WW +: WW) names the k-th warp examined, and slot 0 is examined first. When two candidates conflict, the one examined earlier wins.
- R4: A warp is not granted if it is the primary warp, has exited, has an empty instruction buffer, is waiting, or its next buffered instruction is not valid.
- R5: A warp is not granted if `cand_pc_match` is low (control hazard) or `cand_sb_collide` is high (register collision).
- R6: A warp is granted only if its class field (bits w*3 +: 3 of `cand_class`) equals `prim_class`. The encoding is 1 SP, 2 INT, 3 DP, 4 SFU, 5 tensor, 6 specialized.
- R7: A warp whose active sets (bits w*NS +: NS of `cand_sets`) overlap any set already occupied in the composite is rejected.
- R8: Each grant lowers the free-set count by the granted warp's active-set count. A warp needing more sets than remain is rejected. Once the count is zero, no later warp is granted, even one with no active sets.
- R9: One cycle after an issue cycle, `merged_valid` is high. `merged_occ` is the primary's sets combined with every granted warp's sets. `merged_owner` (WW bits per set, set s at s*WW) holds the primary warp id for primary sets, the granting warp's id for co-issued sets, and 0 for free sets. After a cycle with `prim_valid` low, all three outputs are zero.
- R10: While `rst_n` is low, `merged_valid`, `merged_occ` and `merged_owner` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_en | input | 1 | Lane-group partitioning enabled |
| prim_valid | input | 1 | A primary instruction issued this cycle |
| prim_warp | input | WW | Primary warp id |
| prim_class | input | 3 | Primary functional-unit class |
| prim_occ | input | NS | Sets used by the primary |
| prio_list | input | NW*WW | Warp ids in examination order |
| cand_buf_nonempty | input | NW | Instruction buffer holds an entry, per warp |
| cand_next_valid | input | NW | Next buffered instruction valid, per warp |
| cand_waiting | input | NW | Warp is waiting, per warp |
| cand_exited | input | NW | Warp has exited, per warp |
| cand_pc_match | input | NW | Reconvergence-stack top PC equals instruction PC |
| cand_sb_collide | input | NW | Scoreboard reports a collision |
| cand_class | input | NW*3 | Functional-unit class of each warp's next instruction |
| cand_sets | input | NW*NS | Active-set mask of each warp's next instruction |
| grant | output | NW | Warps co-issued this cycle (buffer advances) |
| merged_valid | output | 1 | Registered: previous cycle carried an issue |
| merged_occ | output | NS | Registered merged occupancy |
| merged_owner | output | NS*WW | Registered per-set owner warp id |

## Verification
The assertions run on every cycle and check these invariants:
- no grant when packing is inactive or no set is free;
- every granted warp is one the eligibility filter passed;
- each grant adds exactly its own set count to the occupancy, which rules out overlap;
- free and occupied sets always add up to the set count;
- the registered occupancy keeps all of the primary's sets.

Some behaviour only the bench scenarios can show: which warp wins when candidates conflict under different priority orders, that each individual disqualifier blocks an otherwise good warp, that a zero-set warp is refused once capacity runs out, and that the owner tags are correct.

// File: rtl/simd_pack_pkg.sv
package simd_pack_pkg;

  typedef enum logic [2:0] {
    FU_NONE   = 3'd0,
    FU_SP     = 3'd1,
    FU_INT    = 3'd2,
    FU_DP     = 3'd3,
    FU_SFU    = 3'd4,
    FU_TENSOR = 3'd5,
    FU_SPEC   = 3'd6,
    FU_MEM    = 3'd7
  } fu_class_e;

  // number of set bits in a mask of up to 64 lane groups
  function automatic int unsigned count_sets(input logic [63:0] mask);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += {31'd0, mask[i]};
    return n;
  endfunction

endpackage

// File: rtl/simd_cand_filter.sv
module simd_cand_filter #(
  parameter int NUM_WARPS = 8,
  localparam int WW = $clog2(NUM_WARPS)
) (
  input  logic [WW-1:0]          prim_warp,
  input  logic [2:0]             prim_class,
  input  logic [NUM_WARPS-1:0]   cand_buf_nonempty,
  input  logic [NUM_WARPS-1:0]   cand_next_valid,
  input  logic [NUM_WARPS-1:0]   cand_waiting,
  input  logic [NUM_WARPS-1:0]   cand_exited,
  input  logic [NUM_WARPS-1:0]   cand_pc_match,
  input  logic [NUM_WARPS-1:0]   cand_sb_collide,
  input  logic [NUM_WARPS*3-1:0] cand_class,
  output logic [NUM_WARPS-1:0]   elig
);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic ready_w, clean_w, same_fu_w, not_prim_w;
    assign ready_w    = cand_buf_nonempty[w] & cand_next_valid[w] &
                        ~cand_waiting[w] & ~cand_exited[w];
    assign clean_w    = cand_pc_match[w] & ~cand_sb_collide[w];
    assign same_fu_w  = (cand_class[w*3 +: 3] == prim_class);
    assign not_prim_w = (WW'(w) != prim_warp);
    assign elig[w]    = ready_w & clean_w & same_fu_w & not_prim_w;
  end

endmodule

// File: rtl/simd_pack_slot.sv
module simd_pack_slot
  import simd_pack_pkg::*;
#(
  parameter int NUM_SETS  = 8,
  parameter int NUM_WARPS = 8,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int CW = $clog2(NUM_SETS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [WW-1:0]                 slot_warp,
  input  logic [NUM_WARPS-1:0]          elig,
  input  logic [NUM_WARPS*NUM_SETS-1:0] cand_sets,
  input  logic [NUM_SETS-1:0]           occ_in,
  input  logic [NUM_SETS*WW-1:0]        own_in,
  input  logic [CW-1:0]                 free_in,
  input  logic [NUM_WARPS-1:0]          gnt_in,
  output logic [NUM_SETS-1:0]           occ_out,
  output logic [NUM_SETS*WW-1:0]        own_out,
  output logic [CW-1:0]                 free_out,
  output logic [NUM_WARPS-1:0]          gnt_out,
  output logic                          take
);

  logic [NUM_SETS-1:0] my_sets;
  logic [CW-1:0]       need;
  logic                overlap, fits;

  assign my_sets = cand_sets[slot_warp*NUM_SETS +: NUM_SETS];
  assign need    = CW'(count_sets(64'(my_sets)));
  assign overlap = |(my_sets & occ_in);
  assign fits    = (need <= free_in);

  // duplicate ids in the priority list are granted at most once
  assign take = enable && (free_in != '0) && elig[slot_warp] &&
                !gnt_in[slot_warp] && !overlap && fits;

  always_comb begin
    occ_out  = occ_in;
    own_out  = own_in;
    free_out = free_in;
    gnt_out  = gnt_in;
    if (take) begin
      occ_out  = occ_in | my_sets;
      free_out = free_in - need;
      gnt_out[slot_warp] = 1'b1;
      for (int s = 0; s < NUM_SETS; s++)
        if (my_sets[s]) own_out[s*WW +: WW] = slot_warp;
    end
  end

  // R7: a grant adds exactly its own set count, so no set is claimed twice
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones(occ_out) == $countones(occ_in) + int'(need)));

  // R8: once capacity is gone this slot passes everything through untouched
  p_stop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (free_in == '0) |-> (gnt_out == gnt_in && occ_out == occ_in));

endmodule

// File: rtl/simd_coissue_packer.sv
module simd_coissue_packer
  import simd_pack_pkg::*;
#(
  parameter int NUM_SETS  = 8,
  parameter int NUM_WARPS = 8,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int CW = $clog2(NUM_SETS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          part_en,
  input  logic                          prim_valid,
  input  logic [WW-1:0]                 prim_warp,
  input  logic [2:0]                    prim_class,
  input  logic [NUM_SETS-1:0]           prim_occ,
  input  logic [NUM_WARPS*WW-1:0]       prio_list,
  input  logic [NUM_WARPS-1:0]          cand_buf_nonempty,
  input  logic [NUM_WARPS-1:0]          cand_next_valid,
  input  logic [NUM_WARPS-1:0]          cand_waiting,
  input  logic [NUM_WARPS-1:0]          cand_exited,
  input  logic [NUM_WARPS-1:0]          cand_pc_match,
  input  logic [NUM_WARPS-1:0]          cand_sb_collide,
  input  logic [NUM_WARPS*3-1:0]        cand_class,
  input  logic [NUM_WARPS*NUM_SETS-1:0] cand_sets,
  output logic [NUM_WARPS-1:0]          grant,
  output logic                          merged_valid,
  output logic [NUM_SETS-1:0]           merged_occ,
  output logic [NUM_SETS*WW-1:0]        merged_owner
);

  logic                   attempt;
  logic [NUM_WARPS-1:0]   elig;
  logic [NUM_WARPS-1:0]   takes;
  logic [NUM_SETS-1:0]    occ_c  [0:NUM_WARPS];
  logic [NUM_SETS*WW-1:0] own_c  [0:NUM_WARPS];
  logic [CW-1:0]          free_c [0:NUM_WARPS];
  logic [NUM_WARPS-1:0]   gnt_c  [0:NUM_WARPS];

  assign attempt = part_en && prim_valid &&
                   (prim_class != FU_NONE) && (prim_class != FU_MEM);

  simd_cand_filter #(.NUM_WARPS(NUM_WARPS)) u_filter (
    .prim_warp         (prim_warp),
    .prim_class        (prim_class),
    .cand_buf_nonempty (cand_buf_nonempty),
    .cand_next_valid   (cand_next_valid),
    .cand_waiting      (cand_waiting),
    .cand_exited       (cand_exited),
    .cand_pc_match     (cand_pc_match),
    .cand_sb_collide   (cand_sb_collide),
    .cand_class        (cand_class),
    .elig              (elig)
  );

  // chain seed: the primary's own sets, tagged with the primary warp
  always_comb begin
    occ_c[0]  = prim_occ;
    own_c[0]  = '0;
    for (int s = 0; s < NUM_SETS; s++)
      if (prim_occ[s]) own_c[0][s*WW +: WW] = prim_warp;
    free_c[0] = CW'(NUM_SETS) - CW'(count_sets(64'(prim_occ)));
    gnt_c[0]  = '0;
  end

  for (genvar k = 0; k < NUM_WARPS; k++) begin : g_slot
    simd_pack_slot #(.NUM_SETS(NUM_SETS), .NUM_WARPS(NUM_WARPS)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (attempt),
      .slot_warp (prio_list[k*WW +: WW]),
      .elig      (elig),
      .cand_sets (cand_sets),
      .occ_in    (occ_c[k]),
      .own_in    (own_c[k]),
      .free_in   (free_c[k]),
      .gnt_in    (gnt_c[k]),
      .occ_out   (occ_c[k+1]),
      .own_out   (own_c[k+1]),
      .free_out  (free_c[k+1]),
      .gnt_out   (gnt_c[k+1]),
      .take      (takes[k])
    );
  end

  assign grant = gnt_c[NUM_WARPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      merged_valid <= 1'b0;
      merged_occ   <= '0;
      merged_owner <= '0;
    end else begin
      merged_valid <= prim_valid;
      merged_occ   <= prim_valid ? occ_c[NUM_WARPS] : '0;
      merged_owner <= prim_valid ? own_c[NUM_WARPS] : '0;
    end
  end

  p_idle_no_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !attempt |-> (grant == '0 && takes == '0));

  p_zero_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&prim_occ) |-> (grant == '0));

  // R4 and R5 as well: only warps the filter passed may be granted
  p_grant_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0);

  p_capacity_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_c[NUM_WARPS]) + $countones(occ_c[NUM_WARPS])) == NUM_SETS);

  p_primary_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |=> (merged_valid && ((merged_occ & $past(prim_occ)) == $past(prim_occ))));

endmodule

// File: tb/simd_coissue_packer_test.sv
`timescale 1ns/1ps
module simd_coissue_packer_test;
  localparam int NS = 8;
  localparam int NW = 8;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          part_en, prim_valid;
  logic [WW-1:0] prim_warp;
  logic [2:0]    prim_class;
  logic [NS-1:0] prim_occ;
  logic [2:0]    b_cls  [NW];
  logic [NS-1:0] b_sets [NW];
  logic [WW-1:0] b_prio [NW];
  logic [NW-1:0] b_ne, b_nv, b_wait, b_exit, b_pcm, b_sb;

  logic [NW*WW-1:0] prio_list;
  logic [NW*3-1:0]  cand_class;
  logic [NW*NS-1:0] cand_sets;
  logic [NW-1:0]    grant;
  logic             merged_valid;
  logic [NS-1:0]    merged_occ;
  logic [NS*WW-1:0] merged_owner;

  always_comb
    for (int i = 0; i < NW; i++) begin
      prio_list[i*WW +: WW] = b_prio[i];
      cand_class[i*3 +: 3]  = b_cls[i];
      cand_sets[i*NS +: NS] = b_sets[i];
    end

  simd_coissue_packer uut (
    .clk(clk), .rst_n(rst_n), .part_en(part_en), .prim_valid(prim_valid),
    .prim_warp(prim_warp), .prim_class(prim_class), .prim_occ(prim_occ),
    .prio_list(prio_list), .cand_buf_nonempty(b_ne), .cand_next_valid(b_nv),
    .cand_waiting(b_wait), .cand_exited(b_exit), .cand_pc_match(b_pcm),
    .cand_sb_collide(b_sb), .cand_class(cand_class), .cand_sets(cand_sets),
    .grant(grant), .merged_valid(merged_valid), .merged_occ(merged_occ),
    .merged_owner(merged_owner));

  int total = 0;
  int bad = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected registered results, produced by the driver, consumed by the monitor
  logic          q_val [$];
  logic [NS-1:0] q_occ [$];
  logic [NS*WW-1:0] q_own [$];
  string         q_tag [$];

  always @(posedge clk) begin
    #2;
    if (q_val.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk({t, " R9 merged_valid"}, 64'(merged_valid), 64'(q_val.pop_front()));
      chk({t, " R9 merged_occ"},   64'(merged_occ),   64'(q_occ.pop_front()));
      chk({t, " R9 merged_owner"}, 64'(merged_owner), 64'(q_own.pop_front()));
    end
  end

  // reference model written from the requirements
  task automatic model(output logic [NW-1:0] g, output logic [NS-1:0] occ,
                       output logic [NS*WW-1:0] own);
    int free;
    bit go;
    g = '0; occ = prim_occ; own = '0;
    for (int s = 0; s < NS; s++) if (prim_occ[s]) own[s*WW +: WW] = prim_warp;
    free = NS - $countones(prim_occ);
    go = part_en && prim_valid && prim_class != 3'd0 && prim_class != 3'd7;
    if (go)
      for (int k = 0; k < NW; k++) begin
        int w;
        w = int'(b_prio[k]);
        if (free == 0) break;
        if (g[w] || w == int'(prim_warp)) continue;
        if (!b_ne[w] || !b_nv[w] || b_wait[w] || b_exit[w]) continue;
        if (!b_pcm[w] || b_sb[w]) continue;
        if (b_cls[w] != prim_class) continue;
        if ((b_sets[w] & occ) != '0) continue;
        if ($countones(b_sets[w]) > free) continue;
        g[w] = 1'b1;
        free -= $countones(b_sets[w]);
        occ |= b_sets[w];
        for (int s = 0; s < NS; s++) if (b_sets[w][s]) own[s*WW +: WW] = WW'(w);
      end
    if (!prim_valid) begin occ = '0; own = '0; end
  endtask

  // driver: called right after a falling edge, returns at the next one
  task automatic apply(string tag);
    logic [NW-1:0] g;
    logic [NS-1:0] o;
    logic [NS*WW-1:0] t;
    model(g, o, t);
    #1;
    chk({tag, " grant"}, 64'(grant), 64'(g));
    q_val.push_back(prim_valid);
    q_occ.push_back(o);
    q_own.push_back(t);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic base();
    part_en = 1; prim_valid = 1; prim_warp = 0; prim_class = 3'd1; prim_occ = 8'h0F;
    b_ne = '1; b_nv = '1; b_wait = '0; b_exit = '0; b_pcm = '1; b_sb = '0;
    for (int i = 0; i < NW; i++) begin
      b_cls[i] = 3'd3; b_sets[i] = '0; b_prio[i] = WW'(i);
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    base();
    prim_valid = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 64'(merged_valid), 0);
    chk("R10 reset occ",   64'(merged_occ), 0);
    chk("R10 reset owner", 64'(merged_owner), 0);
    rst_n = 1;
    @(negedge clk);

    base(); b_cls[1] = 3'd1; b_sets[1] = 8'h30; b_cls[2] = 3'd1; b_sets[2] = 8'hC0;
    apply("R6 basic pack");
    part_en = 0; apply("R1 partition off");
    base(); b_cls[1] = 3'd1; b_sets[1] = 8'h30;
    prim_valid = 0; apply("R1 no primary");
    base(); prim_class = 3'd7; b_cls[1] = 3'd7; b_sets[1] = 8'h30; apply("R1 memory class");
    base(); prim_class = 3'd0; b_cls[1] = 3'd0; b_sets[1] = 8'h30; apply("R1 none class");
    base(); prim_occ = 8'hFF; b_cls[1] = 3'd1; apply("R2 full primary");

    for (int d = 0; d < 7; d++) begin
      base(); b_cls[1] = 3'd1; b_sets[1] = 8'h10;
      case (d)
        0: b_exit[1] = 1;
        1: b_ne[1] = 0;
        2: b_wait[1] = 1;
        3: b_nv[1] = 0;
        4: prim_warp = 1;
        5: b_pcm[1] = 0;
        default: b_sb[1] = 1;
      endcase
      apply(d < 5 ? "R4 disqualified" : "R5 hazard");
    end

    base(); b_cls[1] = 3'd2; b_sets[1] = 8'h10; apply("R6 class mismatch");
    prim_class = 3'd2; apply("R6 INT match");

    base(); b_cls[1] = 3'd1; b_sets[1] = 8'h18; b_cls[2] = 3'd1; b_sets[2] = 8'h10;
    apply("R7 overlap");

    base(); prim_occ = 8'h3F; b_cls[1] = 3'd1; b_sets[1] = 8'hC0;
    b_cls[2] = 3'd1; b_sets[2] = 8'h00; apply("R8 stop when full");
    base(); prim_occ = 8'h3F; b_cls[1] = 3'd1; b_sets[1] = 8'h40;
    b_cls[2] = 3'd1; b_sets[2] = 8'h80; apply("R8 partial fill");

    base(); b_cls[2] = 3'd1; b_sets[2] = 8'h30; b_cls[5] = 3'd1; b_sets[5] = 8'h20;
    apply("R3 identity order");
    for (int i = 0; i < NW; i++) b_prio[i] = WW'(NW - 1 - i);
    apply("R3 reversed order");

    for (int it = 0; it < 60; it++) begin
      base();
      prim_warp  = WW'($urandom_range(0, NW - 1));
      prim_class = 3'($urandom_range(0, 7));
      prim_occ   = NS'($urandom);
      part_en    = ($urandom_range(0, 7) != 0);
      prim_valid = ($urandom_range(0, 7) != 0);
      b_ne = NW'($urandom | $urandom); b_nv = NW'($urandom | $urandom);
      b_wait = NW'($urandom & $urandom); b_exit = NW'($urandom & $urandom);
      b_pcm = NW'($urandom | $urandom); b_sb = NW'($urandom & $urandom);
      for (int i = 0; i < NW; i++) begin
        b_cls[i]  = ($urandom_range(0, 1) != 0) ? prim_class : 3'($urandom);
        b_sets[i] = NS'($urandom & $urandom);
      end
      for (int i = NW - 1; i > 0; i--) begin
        int j;
        logic [WW-1:0] tmp;
        j = $urandom_range(0, i);
        tmp = b_prio[i]; b_prio[i] = b_prio[j]; b_prio[j] = tmp;
      end
      apply("R3 R8 mixed pattern");
    end

    base(); prim_valid = 0;
    apply("R9 idle clears");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule